// File: doc/BRIEF.md
# SPI NAND Page Operation Sequencer

This block runs whole flash operations on a SPI NAND device whose pages hold 2048 data bytes plus 64 spare bytes. A caller presents one operation (page read, page program, block erase or device reset) with a row address, a column and a byte count. The sequencer then issues the needed series of frames to a command framer below it, polls the device status register until the busy bit clears, and finishes with a single done pulse and pass, fail, timeout and ECC results.

Each frame request carries an opcode, a count of address bytes (sent most significant byte of the 24-bit address field first), and the number of data bytes the framer moves out or in. Page data itself flows through the framer directly; the sequencer only sets the lengths. The column address of the cache read and the program load carries a plane-select bit taken from bit 6 of the row and placed at bit 4 of the first column byte.

Top module: `spinand_seq`

## Requirements
- R1: After reset `busy`, `opDone`, `opError`, `opTimeout`, `frmReq` and `eccStatus` are all 0.
- R2: A page read (`opCode`=0) first issues opcode 0x13 with 3 address bytes {0x00, row[15:8], row[7:0]}, then polls status.
- R3: A status poll is opcode 0x0F with 1 address byte 0xC0 and 1 received byte; it is repeated while bit 0 (busy) of the received byte is 1, and status bits 7:6 are taken to be 0.
- R4: Once a read's poll is ready and the ECC field is not 2'b10, opcode 0x03 is issued with 3 address bytes {col[11:8] OR (row[6]<<4), col[7:0], 0xFF} and `xferLen` received bytes; the operation then ends without error.
- R5: A program (`opCode`=1) issues 0x06, polls, then 0x84 with 2 address bytes {col[11:8] OR (row[6]<<4), col[7:0]} (field low byte 0) and `xferLen` sent bytes, then 0x10 with a 3-byte row address as in R2, then polls.
- R6: An erase (`opCode`=2) issues 0x06, polls, then 0xD8 with a 3-byte row address as in R2, then polls.
- R7: On the final ready status, bit 3 set after a program or bit 2 set after an erase ends the operation with `opError`=1; clear bits end it with `opError`=0.
- R8: On the ready status of a read, bits 5:4 are reported on `eccStatus` at `opDone` (00 clean, 01 one bit corrected); 10 ends the read with `opError`=1 and no cache read frame.
- R9: A reset (`opCode`=3) issues 0xFF, then issues no frame for at least `RST_WAIT` cycles, then polls until ready and ends without error.
- R10: If `POLL_LIMIT` consecutive status reads in one poll all show busy, the operation ends with `opTimeout`=1 and no further frame; results of a previous operation are cleared when a new one starts.
- R11: `opValid` is ignored while `busy` is 1: no frame of another operation appears and the running one completes unchanged.
- R12: At most one frame is outstanding: no `frmReq` between a request and its `frmDone`; `opDone` is a one-cycle pulse.
- R13: If the ready status after the write enable of a program or erase has bit 1 (write-enable latch) clear, the operation ends with `opError`=1 and no further frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Start an operation (taken only when idle) |
| opCode | input | 2 | 0 read, 1 program, 2 erase, 3 reset |
| rowAddr | input | 16 | Page or block row address |
| colAddr | input | 12 | Byte column within the page |
| xferLen | input | 12 | Data byte count, 1 to 2112 |
| busy | output | 1 | An operation is in progress |
| opDone | output | 1 | One-cycle completion pulse |
| opError | output | 1 | Operation failed (held until next start) |
| opTimeout | output | 1 | Status polling gave up (held until next start) |
| eccStatus | output | 2 | ECC field of the last read |
| frmReq | output | 1 | One-cycle frame request to the framer |
| frmCmd | output | 8 | Frame opcode |
| frmAddrCnt | output | 2 | Number of address bytes, 0 to 3 |
| frmAddr | output | 24 | Address bytes, first-sent in bits 23:16 |
| frmTxLen | output | 12 | Data bytes to send after the address |
| frmRxLen | output | 12 | Data bytes to receive after the address |
| frmDone | input | 1 | Framer finished the current frame |
| frmRxByte | input | 8 | Last received byte, valid with frmDone |

## Verification
The assertions take for granted that the framer never raises `frmDone` without an outstanding request, that it raises it at least one cycle after `frmReq`, and that status bytes come back with bits 7:6 at zero. The bench's framer model replies a fixed two cycles after each request, answers only status frames from a scripted list whose values keep the reserved bits clear, and returns zero for every other frame, so the stimulus stays inside those assumptions while still driving busy runs, each failure flag, each ECC code and the poll limit.

// File: rtl/spinand_seq_pkg.sv
package spinand_seq_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_RESET = 2'd3
  } opKind_e;

  typedef enum logic [3:0] {
    FK_NONE, FK_WREN, FK_STATUS, FK_ARRAY_READ, FK_CACHE_READ,
    FK_LOAD, FK_EXEC, FK_ERASE, FK_RESET
  } frameKind_e;

  typedef struct packed {
    logic       latchOp;
    logic       issue;
    frameKind_e kind;
    logic       pollClr;
    logic       pollInc;
    logic       waitClr;
    logic       waitInc;
  } seqStrobe_t;

  localparam logic [7:0] CMD_WREN      = 8'h06;
  localparam logic [7:0] CMD_GET_FEAT  = 8'h0F;
  localparam logic [7:0] CMD_ARRAY_RD  = 8'h13;
  localparam logic [7:0] CMD_CACHE_RD  = 8'h03;
  localparam logic [7:0] CMD_LOAD      = 8'h84;
  localparam logic [7:0] CMD_EXEC      = 8'h10;
  localparam logic [7:0] CMD_ERASE     = 8'hD8;
  localparam logic [7:0] CMD_RESET     = 8'hFF;
  localparam logic [7:0] FEAT_STATUS   = 8'hC0;

  // plane select: row bit feeding column-byte bit
  localparam int PLANE_ROW_BIT = 6;
  localparam int PLANE_COL_BIT = 4;

endpackage

// File: rtl/spinand_seq_dp.sv
module spinand_seq_dp
  import spinand_seq_pkg::*;
#(
  parameter int ROW_W      = 16,
  parameter int COL_W      = 12,
  parameter int LEN_W      = 12,
  parameter int POLL_LIMIT = 1000000,
  parameter int RST_WAIT   = 100000
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strb,
  input  logic [1:0]       opCodeIn,
  input  logic [ROW_W-1:0] rowIn,
  input  logic [COL_W-1:0] colIn,
  input  logic [LEN_W-1:0] lenIn,
  input  logic             frmDone,
  output opKind_e          curOp,
  output logic             pollLast,
  output logic             waitDone,
  output logic             frmReq,
  output logic [7:0]       frmCmd,
  output logic [1:0]       frmAddrCnt,
  output logic [23:0]      frmAddr,
  output logic [LEN_W-1:0] frmTxLen,
  output logic [LEN_W-1:0] frmRxLen
);

  localparam int POLL_W = $clog2(POLL_LIMIT + 1);
  localparam int WAIT_W = $clog2(RST_WAIT + 1);

  logic [ROW_W-1:0] rowQ;
  logic [COL_W-1:0] colQ;
  logic [LEN_W-1:0] lenQ;
  logic [POLL_W-1:0] pollCnt;
  logic [WAIT_W-1:0] waitCnt;

  logic [15:0] rowWide, colWide;
  logic [7:0]  colHiByte;
  logic [7:0]  nxtCmd;
  logic [1:0]  nxtCnt;
  logic [23:0] nxtAddr;
  logic [LEN_W-1:0] nxtTx, nxtRx;

  assign rowWide   = 16'(rowQ);
  assign colWide   = 16'(colQ);
  assign colHiByte = colWide[15:8] | (8'(rowWide[PLANE_ROW_BIT]) << PLANE_COL_BIT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curOp <= OP_READ;
      rowQ  <= '0;
      colQ  <= '0;
      lenQ  <= '0;
    end else if (strb.latchOp) begin
      curOp <= opKind_e'(opCodeIn);
      rowQ  <= rowIn;
      colQ  <= colIn;
      lenQ  <= lenIn;
    end
  end

  always_comb begin
    nxtCmd  = CMD_WREN;
    nxtCnt  = 2'd0;
    nxtAddr = '0;
    nxtTx   = '0;
    nxtRx   = '0;
    case (strb.kind)
      FK_STATUS: begin
        nxtCmd = CMD_GET_FEAT; nxtCnt = 2'd1;
        nxtAddr = {FEAT_STATUS, 16'h0000}; nxtRx = LEN_W'(1);
      end
      FK_ARRAY_READ: begin nxtCmd = CMD_ARRAY_RD; nxtCnt = 2'd3; nxtAddr = {8'h00, rowWide}; end
      FK_EXEC:       begin nxtCmd = CMD_EXEC;     nxtCnt = 2'd3; nxtAddr = {8'h00, rowWide}; end
      FK_ERASE:      begin nxtCmd = CMD_ERASE;    nxtCnt = 2'd3; nxtAddr = {8'h00, rowWide}; end
      FK_CACHE_READ: begin
        nxtCmd = CMD_CACHE_RD; nxtCnt = 2'd3;
        nxtAddr = {colHiByte, colWide[7:0], 8'hFF}; nxtRx = lenQ;
      end
      FK_LOAD: begin
        nxtCmd = CMD_LOAD; nxtCnt = 2'd2;
        nxtAddr = {colHiByte, colWide[7:0], 8'h00}; nxtTx = lenQ;
      end
      FK_RESET: nxtCmd = CMD_RESET;
      default:  nxtCmd = CMD_WREN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frmReq     <= 1'b0;
      frmCmd     <= '0;
      frmAddrCnt <= '0;
      frmAddr    <= '0;
      frmTxLen   <= '0;
      frmRxLen   <= '0;
    end else begin
      frmReq <= strb.issue;
      if (strb.issue) begin
        frmCmd     <= nxtCmd;
        frmAddrCnt <= nxtCnt;
        frmAddr    <= nxtAddr;
        frmTxLen   <= nxtTx;
        frmRxLen   <= nxtRx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pollCnt <= '0;
      waitCnt <= '0;
    end else begin
      if (strb.pollClr)      pollCnt <= '0;
      else if (strb.pollInc) pollCnt <= pollCnt + 1'b1;
      if (strb.waitClr)      waitCnt <= '0;
      else if (strb.waitInc) waitCnt <= waitCnt + 1'b1;
    end
  end

  assign pollLast = (pollCnt == POLL_W'(POLL_LIMIT - 1));
  assign waitDone = (waitCnt >= WAIT_W'(RST_WAIT - 1));

  // frame-outstanding tracker seen at the ports
  logic pendQ;
  always_ff @(posedge clk) begin
    if (!rstN)        pendQ <= 1'b0;
    else if (frmReq)  pendQ <= 1'b1;
    else if (frmDone) pendQ <= 1'b0;
  end

  // R12
  one_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    frmReq |-> !pendQ);

  // R10
  poll_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.pollInc |-> !pollLast);

endmodule

// File: rtl/spinand_seq_ctrl.sv
module spinand_seq_ctrl
  import spinand_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic [1:0] opCode,
  input  logic       frmDone,
  input  logic [7:0] frmRxByte,
  input  logic       frmReq,
  input  opKind_e    curOp,
  input  logic       pollLast,
  input  logic       waitDone,
  output seqStrobe_t strb,
  output logic       busy,
  output logic       opDone,
  output logic       opError,
  output logic       opTimeout,
  output logic [1:0] eccStatus
);

  typedef enum logic [3:0] {
    ST_IDLE, ST_WREN, ST_WPOLL, ST_LOAD, ST_ARRAY,
    ST_POLL, ST_CACHE, ST_RST, ST_RSTWAIT
  } state_e;

  state_e state, nState;
  logic   inFlight;
  logic   fin, finErr, finTo, eccCap;
  logic   endFrame, isReady, welSet;
  logic [1:0] eccField;

  assign endFrame = inFlight && frmDone;
  assign isReady  = !frmRxByte[0];
  assign welSet   = frmRxByte[1];
  assign eccField = frmRxByte[5:4];
  assign busy     = (state != ST_IDLE);

  always_comb begin
    strb      = '0;
    strb.kind = FK_NONE;
    nState    = state;
    fin = 1'b0; finErr = 1'b0; finTo = 1'b0; eccCap = 1'b0;
    case (state)
      ST_IDLE: if (opValid) begin
        strb.latchOp = 1'b1;
        strb.pollClr = 1'b1;
        case (opKind_e'(opCode))
          OP_RESET: nState = ST_RST;
          OP_READ:  nState = ST_ARRAY;
          default:  nState = ST_WREN;
        endcase
      end
      ST_WREN: begin
        strb.kind = FK_WREN;
        if (endFrame) nState = ST_WPOLL;
      end
      ST_WPOLL, ST_POLL: begin
        strb.kind = FK_STATUS;
        if (endFrame) begin
          if (!isReady) begin
            if (pollLast) begin fin = 1'b1; finTo = 1'b1; end
            else strb.pollInc = 1'b1;
          end else if (state == ST_WPOLL) begin
            strb.pollClr = 1'b1;
            if (!welSet)              begin fin = 1'b1; finErr = 1'b1; end
            else if (curOp == OP_PROG) nState = ST_LOAD;
            else                       nState = ST_ARRAY;
          end else begin
            case (curOp)
              OP_READ: begin
                eccCap = 1'b1;
                if (eccField == 2'b10) begin fin = 1'b1; finErr = 1'b1; end
                else nState = ST_CACHE;
              end
              OP_PROG:  begin fin = 1'b1; finErr = frmRxByte[3]; end
              OP_ERASE: begin fin = 1'b1; finErr = frmRxByte[2]; end
              default:  fin = 1'b1;
            endcase
          end
        end
      end
      ST_LOAD: begin
        strb.kind = FK_LOAD;
        if (endFrame) nState = ST_ARRAY;
      end
      ST_ARRAY: begin
        strb.kind = (curOp == OP_READ) ? FK_ARRAY_READ :
                    (curOp == OP_PROG) ? FK_EXEC : FK_ERASE;
        if (endFrame) begin nState = ST_POLL; strb.pollClr = 1'b1; end
      end
      ST_CACHE: begin
        strb.kind = FK_CACHE_READ;
        if (endFrame) fin = 1'b1;
      end
      ST_RST: begin
        strb.kind = FK_RESET;
        if (endFrame) begin nState = ST_RSTWAIT; strb.waitClr = 1'b1; end
      end
      ST_RSTWAIT: begin
        strb.waitInc = 1'b1;
        if (waitDone) begin nState = ST_POLL; strb.pollClr = 1'b1; end
      end
      default: nState = ST_IDLE;
    endcase
    if (fin) nState = ST_IDLE;
    // one request per frame step
    strb.issue = !inFlight && (strb.kind != FK_NONE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      inFlight  <= 1'b0;
      opDone    <= 1'b0;
      opError   <= 1'b0;
      opTimeout <= 1'b0;
      eccStatus <= 2'b00;
    end else begin
      state  <= nState;
      opDone <= fin;
      if (strb.issue)   inFlight <= 1'b1;
      else if (frmDone) inFlight <= 1'b0;
      if (strb.latchOp) begin
        opError <= 1'b0; opTimeout <= 1'b0; eccStatus <= 2'b00;
      end else begin
        if (eccCap) eccStatus <= eccField;
        if (fin) begin opError <= finErr; opTimeout <= finTo; end
      end
    end
  end

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    opDone |=> !opDone);

  // R9
  rst_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RSTWAIT) |-> !frmReq);

  // R10
  timeout_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(opTimeout) |-> opDone);

  // R8
  ecc_fail_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opDone && eccStatus == 2'b10) |-> opError);

  // R11
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && opValid) |=> $stable(curOp));

  // R3
  status_rsv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (endFrame && (state == ST_POLL || state == ST_WPOLL)) |-> (frmRxByte[7:6] == 2'b00));

endmodule

// File: rtl/spinand_seq.sv
module spinand_seq
  import spinand_seq_pkg::*;
#(
  parameter int ROW_W      = 16,
  parameter int COL_W      = 12,
  parameter int LEN_W      = 12,
  parameter int POLL_LIMIT = 1000000,
  parameter int RST_WAIT   = 100000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [1:0]       opCode,
  input  logic [ROW_W-1:0] rowAddr,
  input  logic [COL_W-1:0] colAddr,
  input  logic [LEN_W-1:0] xferLen,
  output logic             busy,
  output logic             opDone,
  output logic             opError,
  output logic             opTimeout,
  output logic [1:0]       eccStatus,
  output logic             frmReq,
  output logic [7:0]       frmCmd,
  output logic [1:0]       frmAddrCnt,
  output logic [23:0]      frmAddr,
  output logic [LEN_W-1:0] frmTxLen,
  output logic [LEN_W-1:0] frmRxLen,
  input  logic             frmDone,
  input  logic [7:0]       frmRxByte
);

  seqStrobe_t strb;
  opKind_e    curOp;
  logic       pollLast, waitDone;

  spinand_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .frmDone(frmDone), .frmRxByte(frmRxByte), .frmReq(frmReq),
    .curOp(curOp), .pollLast(pollLast), .waitDone(waitDone),
    .strb(strb), .busy(busy), .opDone(opDone), .opError(opError),
    .opTimeout(opTimeout), .eccStatus(eccStatus)
  );

  spinand_seq_dp #(
    .ROW_W(ROW_W), .COL_W(COL_W), .LEN_W(LEN_W),
    .POLL_LIMIT(POLL_LIMIT), .RST_WAIT(RST_WAIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .opCodeIn(opCode),
    .rowIn(rowAddr), .colIn(colAddr), .lenIn(xferLen), .frmDone(frmDone),
    .curOp(curOp), .pollLast(pollLast), .waitDone(waitDone),
    .frmReq(frmReq), .frmCmd(frmCmd), .frmAddrCnt(frmAddrCnt),
    .frmAddr(frmAddr), .frmTxLen(frmTxLen), .frmRxLen(frmRxLen)
  );

endmodule

// File: tb/spinand_seq_bench.sv
module spinand_seq_bench;

  localparam int PL = 4;
  localparam int RW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opValid = 1'b0;
  logic [1:0] opCode = 2'd0;
  logic [15:0] rowAddr = '0;
  logic [11:0] colAddr = '0;
  logic [11:0] xferLen = '0;
  logic busy, opDone, opError, opTimeout, frmReq;
  logic [1:0] eccStatus, frmAddrCnt;
  logic [7:0] frmCmd;
  logic [23:0] frmAddr;
  logic [11:0] frmTxLen, frmRxLen;
  logic frmDone = 1'b0;
  logic [7:0] frmRxByte = 8'h00;

  always #5 clk = ~clk;

  spinand_seq #(.POLL_LIMIT(PL), .RST_WAIT(RW)) u_spinand_seq (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .rowAddr(rowAddr), .colAddr(colAddr), .xferLen(xferLen),
    .busy(busy), .opDone(opDone), .opError(opError), .opTimeout(opTimeout),
    .eccStatus(eccStatus), .frmReq(frmReq), .frmCmd(frmCmd),
    .frmAddrCnt(frmAddrCnt), .frmAddr(frmAddr), .frmTxLen(frmTxLen),
    .frmRxLen(frmRxLen), .frmDone(frmDone), .frmRxByte(frmRxByte)
  );

  typedef struct {
    logic [7:0]  cmd;
    logic [1:0]  cnt;
    logic [23:0] addr;
    logic [11:0] tx;
    logic [11:0] rx;
    string       tag;
  } frame_t;

  frame_t expQ[$];
  logic [7:0] statQ[$];
  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int respCnt = 0;
  logic [7:0] respByte = 8'h00;
  bit gapArmed = 0;
  bit rstPending = 0;
  int rstDoneCyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic expFrame(input logic [7:0] c, input logic [1:0] n, input logic [23:0] a,
                          input logic [11:0] t, input logic [11:0] r, input string tag);
    frame_t f;
    f.cmd = c; f.cnt = n; f.addr = a; f.tx = t; f.rx = r; f.tag = tag;
    expQ.push_back(f);
  endtask

  task automatic expStatus(input logic [7:0] s, input string tag);
    expFrame(8'h0F, 2'd1, 24'hC00000, 12'd0, 12'd1, tag);
    statQ.push_back(s);
  endtask

  // monitor and framer model
  always @(negedge clk) begin
    frmDone = 1'b0;
    if (respCnt > 0) begin
      respCnt--;
      if (respCnt == 0) begin
        frmDone = 1'b1;
        frmRxByte = respByte;
        if (rstPending) begin rstPending = 0; rstDoneCyc = cyc; gapArmed = 1; end
      end
    end
    if (frmReq) begin
      if (gapArmed) begin
        gapArmed = 0;
        // R9: quiet window after the reset frame
        check((cyc - rstDoneCyc) >= RW, "R9 reset wait", cyc - rstDoneCyc, RW);
      end
      if (expQ.size() == 0) begin
        check(0, "R11 unexpected frame", {24'h0, frmCmd}, 32'h0);
      end else begin
        frame_t e;
        e = expQ.pop_front();
        check(frmCmd == e.cmd && frmAddrCnt == e.cnt && frmAddr == e.addr &&
              frmTxLen == e.tx && frmRxLen == e.rx,
              e.tag, {frmCmd, frmAddr}, {e.cmd, e.addr});
        check(frmTxLen == e.tx && frmRxLen == e.rx && frmAddrCnt == e.cnt,
              e.tag, {6'h0, frmAddrCnt, frmTxLen, frmRxLen}, {6'h0, e.cnt, e.tx, e.rx});
      end
      respCnt = 2;
      if (frmCmd == 8'h0F) respByte = (statQ.size() > 0) ? statQ.pop_front() : 8'h01;
      else respByte = 8'h00;
      if (frmCmd == 8'hFF) rstPending = 1;
    end
  end

  task automatic runOp(input logic [1:0] op, input logic [15:0] row, input logic [11:0] col,
                       input logic [11:0] len, input bit injectBusy,
                       input bit expErr, input bit expTo, input logic [1:0] expEcc,
                       input string tag);
    int waitN;
    @(negedge clk);
    opValid = 1'b1; opCode = op; rowAddr = row; colAddr = col; xferLen = len;
    @(negedge clk);
    opValid = 1'b0; rowAddr = '0; colAddr = '0;
    if (injectBusy) begin
      repeat (4) @(negedge clk);
      // R11: new start while busy must be ignored
      check(busy == 1'b1, "R11 busy", {31'h0, busy}, 32'h1);
      opValid = 1'b1; opCode = 2'd3; rowAddr = 16'hAAAA;
      @(negedge clk);
      opValid = 1'b0;
    end
    waitN = 0;
    while (!opDone && waitN < 2000) begin @(negedge clk); waitN++; end
    check(opDone == 1'b1, {tag, " done"}, {31'h0, opDone}, 32'h1);
    check(opError == expErr, {tag, " error"}, {31'h0, opError}, {31'h0, expErr});
    check(opTimeout == expTo, {tag, " R10 timeout"}, {31'h0, opTimeout}, {31'h0, expTo});
    check(eccStatus == expEcc, {tag, " R8 ecc"}, {30'h0, eccStatus}, {30'h0, expEcc});
    repeat (6) @(negedge clk);
    check(expQ.size() == 0, {tag, " missing frames"}, expQ.size(), 0);
    check(busy == 1'b0 && opDone == 1'b0, {tag, " R12 idle"}, {30'h0, busy, opDone}, 0);
    expQ.delete();
    statQ.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    check(!busy && !opDone && !opError && !opTimeout && !frmReq && eccStatus == 2'b00,
          "R1 reset state", {26'h0, busy, opDone, opError, opTimeout, frmReq, eccStatus[0]}, 0);

    // R2 R4 R8: read with one busy poll, one-bit corrected, plane bit set
    expFrame(8'h13, 2'd3, 24'h001240, 0, 0, "R2 array read");
    expStatus(8'h01, "R3 poll busy");
    expStatus(8'h10, "R3 poll ready");
    expFrame(8'h03, 2'd3, 24'h1123FF, 0, 12'h840, "R4 cache read");
    runOp(2'd0, 16'h1240, 12'h123, 12'h840, 0, 0, 0, 2'b01, "R4 read");

    // R8: uncorrectable, no cache read
    expFrame(8'h13, 2'd3, 24'h000005, 0, 0, "R2 array read");
    expStatus(8'h20, "R8 poll");
    runOp(2'd0, 16'h0005, 12'h000, 12'd16, 0, 1, 0, 2'b10, "R8 read");

    // R5: program pass, plane bit clear
    expFrame(8'h06, 2'd0, 24'h0, 0, 0, "R5 wren");
    expStatus(8'h02, "R5 wel poll");
    expFrame(8'h84, 2'd2, 24'h080000, 12'd64, 0, "R5 load");
    expFrame(8'h10, 2'd3, 24'h000081, 0, 0, "R5 exec");
    expStatus(8'h01, "R3 poll busy");
    expStatus(8'h00, "R5 poll ready");
    runOp(2'd1, 16'h0081, 12'h800, 12'd64, 0, 0, 0, 2'b00, "R5 program");

    // R7 R11: program fail with an ignored start while busy
    expFrame(8'h06, 2'd0, 24'h0, 0, 0, "R5 wren");
    expStatus(8'h02, "R5 wel poll");
    expFrame(8'h84, 2'd2, 24'h100500, 12'd8, 0, "R5 load plane");
    expFrame(8'h10, 2'd3, 24'h000040, 0, 0, "R5 exec");
    expStatus(8'h08, "R7 pfail");
    runOp(2'd1, 16'h0040, 12'h005, 12'd8, 1, 1, 0, 2'b00, "R7 program fail");

    // R6 R7: erase fail
    expFrame(8'h06, 2'd0, 24'h0, 0, 0, "R6 wren");
    expStatus(8'h02, "R6 wel poll");
    expFrame(8'hD8, 2'd3, 24'h000140, 0, 0, "R6 erase");
    expStatus(8'h04, "R7 efail");
    runOp(2'd2, 16'h0140, 12'h0, 12'd1, 0, 1, 0, 2'b00, "R7 erase fail");

    // R6: erase pass
    expFrame(8'h06, 2'd0, 24'h0, 0, 0, "R6 wren");
    expStatus(8'h02, "R6 wel poll");
    expFrame(8'hD8, 2'd3, 24'h00FFC0, 0, 0, "R6 erase");
    expStatus(8'h01, "R3 poll busy");
    expStatus(8'h00, "R6 poll ready");
    runOp(2'd2, 16'hFFC0, 12'h0, 12'd1, 0, 0, 0, 2'b00, "R6 erase");

    // R13: write-enable latch not set
    expFrame(8'h06, 2'd0, 24'h0, 0, 0, "R13 wren");
    expStatus(8'h00, "R13 wel clear");
    runOp(2'd2, 16'h0010, 12'h0, 12'd1, 0, 1, 0, 2'b00, "R13 erase");

    // R9: reset
    expFrame(8'hFF, 2'd0, 24'h0, 0, 0, "R9 reset");
    expStatus(8'h01, "R9 poll busy");
    expStatus(8'h00, "R9 poll ready");
    runOp(2'd3, 16'h0, 12'h0, 12'd1, 0, 0, 0, 2'b00, "R9 reset");

    // R10: timeout after PL busy polls
    expFrame(8'h06, 2'd0, 24'h0, 0, 0, "R6 wren");
    expStatus(8'h02, "R6 wel poll");
    expFrame(8'hD8, 2'd3, 24'h000080, 0, 0, "R6 erase");
    for (int i = 0; i < PL; i++) expStatus(8'h01, "R10 poll busy");
    runOp(2'd2, 16'h0080, 12'h0, 12'd1, 0, 0, 1, 2'b00, "R10 erase timeout");

    // R10: results cleared by next start; clean read
    expFrame(8'h13, 2'd3, 24'h000007, 0, 0, "R2 array read");
    expStatus(8'h00, "R3 poll ready");
    expFrame(8'h03, 2'd3, 24'h0000FF, 0, 12'd1, "R4 cache read");
    runOp(2'd0, 16'h0007, 12'h000, 12'd1, 0, 0, 0, 2'b00, "R10 clear read");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc >= 100000);
    check(0, "watchdog", cyc, 100000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule